// File: doc/BRIEF.md
# Selectable Pseudorandom Test Pattern Generator

This block produces a serial test bit stream for link and channel testing, one bit per clock on which the bit enable is high. A bank bit and a 3-bit code choose one sequence from a set of maximal-length pseudorandom sequences, a zero-suppressed pseudorandom variant, a user-defined repeating word of programmable length, and an alternating two-halfword pattern. An invert control flips every generated bit. Codes that select nothing are reported on a flag, and the output is parked at one while such a code is applied.

The selection inputs are sampled on every clock. Any change of bank, code or length restarts the chosen sequence from a known state, so a shift register can never be left in the all-zero state. The 32-bit pattern word is read live, so software may rewrite it while a word-based pattern runs.

Top module: `tpg_top`

## Requirements
- R1: With bank 0, codes 000, 001 and 010 give Fibonacci sequences of period 127, 2047 and 32767 from x^7+x^6+1, x^11+x^9+1 and x^15+x^14+1. The register shifts toward its MSB, the new LSB is the XOR of the two tap bits (bit n-1 and bit k-1 for x^n+x^k+1), and the output is the register MSB.
- R2: With bank 0, code 011 gives the zero-suppressed sequence: a 20-bit register on x^20+x^3+1, whose output is one when bit 19 is one or when bits 18 down to 5 are all zero, and otherwise zero.
- R3: With bank 1, codes 000, 001 and 010 give sequences from x^9+x^5+1, x^20+x^17+1 (no zero suppression) and x^23+x^18+1, built as in R1. Bank 1 codes 011 to 111 are illegal.
- R4: With bank 0, code 100 repeats the low L+1 bits of the pattern word, where L is the 4-bit length input. Bit L is sent first and bit 0 last.
- R5: With bank 0, code 101 sends pattern word bits 15 down to 0, then bits 31 down to 16, and repeats.
- R6: Bank 0 codes 110 and 111 and the bank 1 codes named in R3 raise the illegal flag. While the flag is high, the serial output is one whatever the invert input.
- R7: When the invert input is high, the serial output of every legal pattern is the complement of the generated bit. The invert input acts in the same cycle.
- R8: A change of bank, code or length takes effect at the next rising clock edge. The shift register then holds all ones and the word position returns to the first bit. The bit enable has no effect on that edge.
- R9: On an edge where the bit enable is low and the selection is unchanged, the sequence does not advance, so the output holds.
- R10: The reset is synchronous and active high. It loads the sequence start state for the selection present at its inputs. After reset is released, the first bit is that sequence's first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Advance the sequence by one bit |
| bank_sel | input | 1 | Pattern bank select |
| pat_sel | input | 3 | Pattern code within the bank |
| tx_inv | input | 1 | Invert the generated bits |
| rep_len | input | 4 | Repeating-word length minus one |
| pat_word | input | 32 | Word for the repeating and alternating patterns |
| ser_out | output | 1 | Serial test bit |
| illegal | output | 1 | Current selection is not a legal pattern |

## Verification
Each of the seven shift-register sequences runs for hundreds to thousands of bits against a model built from its polynomial. A wrong tap or a wrong width shows up within a few bits, and the 127-bit repeat check separates a maximal sequence from a short cycle. The zero-suppressed mode runs long enough to cover its forced-one rule. The repeating word is tried at lengths 1, 6 and 16 and with the word rewritten in mid-run, which reveals bit-order and period errors. The alternating pattern uses halves with distinct values, so swapped halves are seen. Bursty enables, switches in mid-run, invert toggling, every illegal code with invert set, and a reset in mid-sequence separate the hold, restart and masking rules from the plain sequence generation.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int unsigned LFSR_W = 23;

    typedef enum logic [3:0] {
        M_P7, M_P11, M_P15, M_QRSS, M_REP, M_ALT,
        M_P9, M_P20, M_P23, M_ILL
    } mode_e;

    typedef struct packed {
        logic bit_val;
        logic flag;
    } tpg_out_t;

    function automatic mode_e decode_sel(logic bank, logic [2:0] code);
        mode_e m;
        m = M_ILL;
        if (!bank) begin
            case (code)
                3'd0: m = M_P7;
                3'd1: m = M_P11;
                3'd2: m = M_P15;
                3'd3: m = M_QRSS;
                3'd4: m = M_REP;
                3'd5: m = M_ALT;
                default: m = M_ILL;
            endcase
        end else begin
            case (code)
                3'd0: m = M_P9;
                3'd1: m = M_P20;
                3'd2: m = M_P23;
                default: m = M_ILL;
            endcase
        end
        return m;
    endfunction

    function automatic int unsigned lfsr_len(mode_e m);
        case (m)
            M_P7:   return 7;
            M_P9:   return 9;
            M_P11:  return 11;
            M_P15:  return 15;
            M_QRSS: return 20;
            M_P20:  return 20;
            M_P23:  return 23;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned lfsr_tap(mode_e m);
        case (m)
            M_P7:   return 6;
            M_P9:   return 5;
            M_P11:  return 9;
            M_P15:  return 14;
            M_QRSS: return 3;
            M_P20:  return 17;
            M_P23:  return 18;
            default: return 1;
        endcase
    endfunction

    function automatic logic is_lfsr(mode_e m);
        return lfsr_len(m) != 0;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_mask(int unsigned w);
        return ~({LFSR_W{1'b1}} << w);
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_next(mode_e m, logic [LFSR_W-1:0] s);
        int unsigned w;
        int unsigned t;
        logic fb;
        w = lfsr_len(m);
        t = lfsr_tap(m);
        if (w == 0) return s;
        fb = s[w-1] ^ s[t-1];
        return ((s << 1) | {{(LFSR_W-1){1'b0}}, fb}) & lfsr_mask(w);
    endfunction

    function automatic logic lfsr_out(mode_e m, logic [LFSR_W-1:0] s);
        int unsigned w;
        w = lfsr_len(m);
        if (w == 0) return 1'b0;
        if (m == M_QRSS) return s[19] | ~(|s[18:5]);
        return s[w-1];
    endfunction

endpackage

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
    import tpg_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bank_sel,
    input  logic [2:0]       pat_sel,
    input  logic [LEN_W-1:0] rep_len,
    output mode_e            dec_mode,
    output mode_e            mode_q,
    output logic [LEN_W-1:0] len_q,
    output logic             reload
);

    always_comb begin
        dec_mode = decode_sel(bank_sel, pat_sel);
        reload   = !rst && ((dec_mode != mode_q) || (rep_len != len_q));
    end

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            mode_q <= dec_mode;
            len_q  <= rep_len;
        end
    end

endmodule

// File: rtl/tpg_lfsr.sv
module tpg_lfsr
    import tpg_pkg::*;
(
    input  logic  clk,
    input  logic  load,
    input  logic  adv,
    input  mode_e mode,
    output logic  prbs_bit
);

    logic [LFSR_W-1:0] state;

    always_ff @(posedge clk) begin
        if (load) begin
            state <= '1;
        end else if (adv) begin
            state <= lfsr_next(mode, state);
        end
    end

    always_comb prbs_bit = lfsr_out(mode, state);

endmodule

// File: rtl/tpg_word_seq.sv
module tpg_word_seq
    import tpg_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              load,
    input  logic              adv,
    input  mode_e             mode,
    input  logic [LEN_W-1:0]  len,
    input  logic [WORD_W-1:0] word,
    output logic              word_bit
);

    localparam int IDX_W = $clog2(WORD_W);
    localparam int HALF  = WORD_W / 2;

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] sel_v;
    int               last_i;
    int               sel_i;

    always_comb begin
        case (mode)
            M_REP: begin
                last_i = int'(len);
                sel_i  = int'(len) - int'(idx);
            end
            M_ALT: begin
                last_i = WORD_W - 1;
                sel_i  = (int'(idx) < HALF) ? (HALF - 1 - int'(idx))
                                            : (WORD_W + HALF - 1 - int'(idx));
            end
            default: begin
                last_i = 0;
                sel_i  = 0;
            end
        endcase
        sel_v    = sel_i[IDX_W-1:0];
        word_bit = word[sel_v];
    end

    always_ff @(posedge clk) begin
        if (load) begin
            idx <= '0;
        end else if (adv) begin
            idx <= (int'(idx) == last_i) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              bank_sel,
    input  logic [2:0]        pat_sel,
    input  logic              tx_inv,
    input  logic [LEN_W-1:0]  rep_len,
    input  logic [WORD_W-1:0] pat_word,
    output logic              ser_out,
    output logic              illegal
);

    mode_e            dec_mode;
    mode_e            mode_q;
    logic [LEN_W-1:0] len_q;
    logic             reload;
    logic             load;
    logic             prbs_bit;
    logic             word_bit;
    tpg_out_t         res;

    tpg_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .bank_sel (bank_sel),
        .pat_sel  (pat_sel),
        .rep_len  (rep_len),
        .dec_mode (dec_mode),
        .mode_q   (mode_q),
        .len_q    (len_q),
        .reload   (reload)
    );

    always_comb load = rst || reload;

    tpg_lfsr u_lfsr (
        .clk      (clk),
        .load     (load),
        .adv      (bit_en),
        .mode     (mode_q),
        .prbs_bit (prbs_bit)
    );

    tpg_word_seq #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_word (
        .clk      (clk),
        .load     (load),
        .adv      (bit_en),
        .mode     (mode_q),
        .len      (len_q),
        .word     (pat_word),
        .word_bit (word_bit)
    );

    always_comb begin
        case (mode_q)
            M_ILL:        res = '{bit_val: 1'b1, flag: 1'b1};
            M_REP, M_ALT: res = '{bit_val: word_bit ^ tx_inv, flag: 1'b0};
            default:      res = '{bit_val: prbs_bit ^ tx_inv, flag: 1'b0};
        endcase
        ser_out = res.bit_val;
        illegal = res.flag;
    end

endmodule

// File: rtl/tpg_chk.sv
module tpg_chk
    import tpg_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic              bank_sel,
    input logic [2:0]        pat_sel,
    input logic              tx_inv,
    input logic [LEN_W-1:0]  rep_len,
    input logic [WORD_W-1:0] pat_word,
    input logic              ser_out,
    input logic              illegal,
    input logic              reload,
    input mode_e             dec_mode
);

    localparam int HALF = WORD_W / 2;

    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    // R6
    ill_force_one_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> ser_out);

    // R3
    bank1_ill_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_sel && pat_sel >= 3'd3 && $stable(bank_sel) && $stable(pat_sel))
        |-> illegal);

    // R8
    prbs_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (reload && is_lfsr(dec_mode)) |=> (ser_out != tx_inv));

    // R5
    alt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (reload && dec_mode == M_ALT) |=> (ser_out == (pat_word[HALF-1] ^ tx_inv)));

    // R4
    rep_single_chk: assert property (@(posedge clk) disable iff (rst)
        (reload && dec_mode == M_REP && rep_len == '0)
        |=> (ser_out == (pat_word[0] ^ tx_inv)));

    // R9
    hold_no_en_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(bit_en) && !$past(reload) && $stable(tx_inv) && $stable(pat_word))
        |-> $stable(ser_out));

endmodule

bind tpg_top tpg_chk #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .bank_sel (bank_sel),
    .pat_sel  (pat_sel),
    .tx_inv   (tx_inv),
    .rep_len  (rep_len),
    .pat_word (pat_word),
    .ser_out  (ser_out),
    .illegal  (illegal),
    .reload   (reload),
    .dec_mode (dec_mode)
);

// File: tb/tb_tpg_top.sv
module tb_tpg_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_en;
    logic        bank_sel;
    logic [2:0]  pat_sel;
    logic        tx_inv;
    logic [3:0]  rep_len;
    logic [31:0] pat_word;
    logic        ser_out;
    logic        illegal;

    always #5 clk = ~clk;

    tpg_top dut (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .bank_sel (bank_sel),
        .pat_sel  (pat_sel),
        .tx_inv   (tx_inv),
        .rep_len  (rep_len),
        .pat_word (pat_word),
        .ser_out  (ser_out),
        .illegal  (illegal)
    );

    typedef struct {
        logic  b;
        logic  ill;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    errors = 0;
    string tag    = "R10";
    logic  last_act;

    // model: mode codes 7,9,11,15,20,23 = plain sequence width, 100 = zero-suppressed,
    // 200 = repeating word, 300 = alternating, -1 = illegal
    int          m_mode;
    int          m_len;
    int          m_idx;
    logic [22:0] m_s;
    logic [7:0]  en_rng = 8'hA7;

    function automatic int tb_decode(logic b, logic [2:0] c);
        if (!b) begin
            case (c)
                3'd0: return 7;
                3'd1: return 11;
                3'd2: return 15;
                3'd3: return 100;
                3'd4: return 200;
                3'd5: return 300;
                default: return -1;
            endcase
        end
        case (c)
            3'd0: return 9;
            3'd1: return 20;
            3'd2: return 23;
            default: return -1;
        endcase
    endfunction

    function automatic int tb_width(int m);
        return (m == 100) ? 20 : ((m > 0 && m < 100) ? m : 0);
    endfunction

    function automatic int tb_tap(int m);
        case (m)
            7: return 6;
            9: return 5;
            11: return 9;
            15: return 14;
            20: return 17;
            23: return 18;
            100: return 3;
            default: return 1;
        endcase
    endfunction

    task automatic model_edge();
        int dec;
        int w;
        logic fb;
        dec = tb_decode(bank_sel, pat_sel);
        if (rst || dec != m_mode || int'(rep_len) != m_len) begin
            m_mode = dec;
            m_len  = int'(rep_len);
            m_s    = '1;
            m_idx  = 0;
        end else if (bit_en) begin
            w = tb_width(m_mode);
            if (w != 0) begin
                fb  = m_s[w-1] ^ m_s[tb_tap(m_mode)-1];
                m_s = {m_s[21:0], fb};
                for (int i = w; i < 23; i++) m_s[i] = 1'b0;
            end else if (m_mode == 200) begin
                m_idx = (m_idx == m_len) ? 0 : m_idx + 1;
            end else if (m_mode == 300) begin
                m_idx = (m_idx == 31) ? 0 : m_idx + 1;
            end
        end
    endtask

    function automatic exp_t model_out();
        exp_t e;
        logic g;
        int w;
        e.tag = tag;
        e.ill = 1'b0;
        w = tb_width(m_mode);
        if (m_mode == -1) begin
            e.b = 1'b1;
            e.ill = 1'b1;
            return e;
        end
        if (m_mode == 100)      g = m_s[19] | (m_s[18:5] == 14'd0);
        else if (w != 0)        g = m_s[w-1];
        else if (m_mode == 200) g = pat_word[m_len - m_idx];
        else                    g = (m_idx < 16) ? pat_word[15 - m_idx] : pat_word[47 - m_idx];
        e.b = g ^ tx_inv;
        return e;
    endfunction

    // monitor: pops the expectation pushed for this cycle
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            last_act = ser_out;
            if (ser_out !== e.b || illegal !== e.ill) begin
                errors++;
                $display("FAIL %s: ser_out=%0b illegal=%0b expected ser_out=%0b illegal=%0b",
                         e.tag, ser_out, illegal, e.b, e.ill);
            end
        end
    end

    // driver: one clock, model updated at the edge, expectation queued
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        sb_q.push_back(model_out());
        #2;
    endtask

    task automatic set_sel(logic b, logic [2:0] c, logic [3:0] l, logic inv);
        bank_sel = b;
        pat_sel  = c;
        rep_len  = l;
        tx_inv   = inv;
    endtask

    task automatic run(int n, bit bursty);
        for (int i = 0; i < n; i++) begin
            if (bursty) begin
                en_rng = {en_rng[6:0], en_rng[7] ^ en_rng[5] ^ en_rng[4] ^ en_rng[3]};
                bit_en = en_rng[0];
            end else begin
                bit_en = 1'b1;
            end
            tick();
        end
        bit_en = 1'b1;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic seq [0:253];

    initial begin
        rst = 1'b1;
        bit_en = 1'b1;
        pat_word = 32'h0;
        set_sel(1'b0, 3'd0, 4'd0, 1'b0);
        m_mode = 7; m_len = 0; m_idx = 0; m_s = '1;
        tag = "R10";
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;

        // R1: period 127 sequence, plus explicit repeat check
        tag = "R1";
        for (int i = 0; i < 254; i++) begin
            tick();
            seq[i] = last_act;
        end
        begin
            int mism;
            mism = 0;
            for (int i = 0; i < 127; i++) if (seq[i] != seq[i+127]) mism++;
            checks++;
            if (mism != 0) begin
                errors++;
                $display("FAIL R1: period-127 mismatches=%0d expected 0", mism);
            end
        end
        set_sel(1'b0, 3'd1, 4'd0, 1'b0); run(400, 0);
        set_sel(1'b0, 3'd2, 4'd0, 1'b0); run(400, 0);

        // R2: zero-suppressed sequence
        tag = "R2";
        set_sel(1'b0, 3'd3, 4'd0, 1'b0); run(4000, 0);

        // R3: second bank sequences and its illegal codes
        tag = "R3";
        set_sel(1'b1, 3'd0, 4'd0, 1'b0); run(600, 0);
        set_sel(1'b1, 3'd1, 4'd0, 1'b0); run(600, 0);
        set_sel(1'b1, 3'd2, 4'd0, 1'b0); run(600, 0);
        for (int c = 3; c < 8; c++) begin
            set_sel(1'b1, 3'(c), 4'd0, 1'b0); run(4, 0);
        end

        // R4: repeating word at several lengths, word rewritten mid-run
        tag = "R4";
        pat_word = 32'hDEAD_0001;
        set_sel(1'b0, 3'd4, 4'd0, 1'b0); run(20, 0);
        pat_word = 32'h0000_002B;
        set_sel(1'b0, 3'd4, 4'd5, 1'b0); run(40, 0);
        pat_word = 32'h1234_A5C3;
        set_sel(1'b0, 3'd4, 4'd15, 1'b0); run(50, 0);
        pat_word = 32'h0000_3C0F; run(40, 0);

        // R5: alternating halves
        tag = "R5";
        pat_word = 32'h1234_ABCD;
        set_sel(1'b0, 3'd5, 4'd0, 1'b0); run(100, 0);

        // R6: illegal codes with invert set
        tag = "R6";
        set_sel(1'b0, 3'd6, 4'd0, 1'b1); run(5, 0);
        set_sel(1'b0, 3'd7, 4'd0, 1'b1); run(5, 0);
        set_sel(1'b1, 3'd4, 4'd0, 1'b1); run(5, 0);

        // R7: inversion, toggled live
        tag = "R7";
        set_sel(1'b1, 3'd0, 4'd0, 1'b1); run(100, 0);
        tx_inv = 1'b0; run(20, 0);
        tx_inv = 1'b1; pat_word = 32'h8001_7FFE;
        set_sel(1'b0, 3'd5, 4'd0, 1'b1); run(64, 0);

        // R9: bursty enable
        tag = "R9";
        set_sel(1'b0, 3'd0, 4'd0, 1'b0); run(300, 1);
        pat_word = 32'h0000_9A6B;
        set_sel(1'b0, 3'd4, 4'd11, 1'b0); run(200, 1);
        set_sel(1'b1, 3'd2, 4'd11, 1'b0); run(300, 1);

        // R8: switches in mid-run restart the sequence, enable low on switch edge
        tag = "R8";
        set_sel(1'b0, 3'd2, 4'd0, 1'b0); run(50, 0);
        set_sel(1'b0, 3'd0, 4'd0, 1'b0); bit_en = 1'b0; tick(); run(10, 0);
        set_sel(1'b0, 3'd2, 4'd0, 1'b0); run(10, 0);
        set_sel(1'b0, 3'd2, 4'd3, 1'b0); run(10, 0);
        pat_word = 32'h0000_00A5;
        set_sel(1'b0, 3'd4, 4'd7, 1'b0); run(13, 0);
        set_sel(1'b0, 3'd4, 4'd3, 1'b0); run(12, 0);

        // R10: reset in mid-sequence
        tag = "R10";
        set_sel(1'b0, 3'd1, 4'd0, 1'b0); run(37, 0);
        rst = 1'b1; tick();
        rst = 1'b0; run(30, 0);

        @(negedge clk);
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule